// File: doc/BRIEF.md
# Upset-Detection Memory Scrub Tester

This block is a self-test engine that watches on-chip storage for bits flipped by radiation. In every test cycle it fills a block RAM and a separate flip-flop register bank with an alternating one/zero pattern. It then leaves both untouched for a long dwell interval, counted in clock cycles. Finally it reads every word back and counts, bit by bit, how many no longer match what was written.

Each test cycle ends with a result record on a valid/ready output, meant for a host logger. The record carries a 32-bit cycle index, the pattern phase used, and separate error counts for the RAM and for the register bank. Once started, the engine loops without further intervention, so very long runs can be collected. A stop request lets the cycle in progress finish and report before the engine goes idle.

A test-only fault input can flip one chosen stored bit per clock during the dwell. A testbench uses it to predict exact error counts.

Top module: `scrub_tester`

## Requirements
- R1: After reset, `rec_valid_o` and `busy_o` are 0. Without a `start_i` pulse, the engine stays idle and emits no record.
- R2: Test cycle k writes the pattern with bit i equal to 1 for even i (0x55 per byte) when k is even, and the inverted pattern (0xAA per byte) when k is odd. `rec_phase_o` reports k modulo 2.
- R3: With RAM_WORDS = 16 * REG_WORDS, the first record's `rec_valid_o` rises exactly 2*RAM_WORDS + DWELL_CYCLES + 1 clock edges after the edge that samples `start_i`, and is 0 one edge earlier.
- R4: `rec_cycle_o` is 0 for the first record after reset and rises by one for each accepted record. It keeps counting across stop and restart.
- R5: `rec_ram_err_o` equals the number of distinct RAM bits flipped during that cycle's dwell, and is 0 when none were flipped.
- R6: `rec_reg_err_o` counts flipped register-bank bits independently of RAM flips.
- R7: Each error count saturates at 2^ERR_W - 1 and never wraps.
- R8: Errors do not carry over. A cycle that follows a faulty cycle and sees no new flips reports 0 and 0.
- R9: While `rec_valid_o` is 1 and `rec_ready_i` is 0, the engine stalls, and the record stays valid and unchanged.
- R10: While running, the next cycle's write phase starts on the edge after the handshake, so the next record arrives 2*RAM_WORDS + DWELL_CYCLES + 1 edges after that handshake edge.
- R11: A `stop_i` pulse while busy takes effect only after the current cycle's record is accepted. The engine then returns to idle with `busy_o` = 0 and sends no further records.
- R12: When `inj_en_i` is 1 during the dwell, the bit `inj_bit_i` of word `inj_word_i` is inverted. The RAM is targeted when `inj_ram_i` is 1 and the register bank when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start the loop when idle |
| stop_i | input | 1 | Request stop at end of the current cycle |
| inj_en_i | input | 1 | Test-only fault injection enable |
| inj_ram_i | input | 1 | Injection target: 1 RAM, 0 register bank |
| inj_word_i | input | RAM_AW | Word index for injection |
| inj_bit_i | input | BIT_W | Bit index for injection |
| rec_ready_i | input | 1 | Logger accepts the record |
| rec_valid_o | output | 1 | Record available |
| rec_cycle_o | output | 32 | Test cycle index |
| rec_phase_o | output | 1 | Pattern phase of this cycle |
| rec_ram_err_o | output | ERR_W | RAM bit error count |
| rec_reg_err_o | output | ERR_W | Register bank bit error count |
| busy_o | output | 1 | Engine running |

## Verification
A record is due 2*RAM_WORDS + DWELL_CYCLES + 1 edges after the edge that starts its cycle. That starting edge is either the one that samples `start_i` or the previous record's handshake edge. Injections are accepted only on the dwell edges, which run from RAM_WORDS+1 to RAM_WORDS+DWELL_CYCLES after that start. The bench keeps its own edge counter, drives each input just after a chosen edge, and reads `rec_valid_o` one edge before and exactly on the due edge. It tracks every stall so that it can move the next cycle's start accordingly. Expected records are queued by the driver and compared by a monitor at every handshake.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

    localparam int CYCLE_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WRITE  = 3'd1,
        ST_DWELL  = 3'd2,
        ST_READ   = 3'd3,
        ST_REPORT = 3'd4
    } scrub_state_e;

    // Number of set bits in a word of up to 64 bits.
    function automatic logic [7:0] pop64(input logic [63:0] v);
        logic [7:0] n;
        n = '0;
        for (int i = 0; i < 64; i++) begin
            n = n + 8'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/scrub_store.sv
module scrub_store #(
    parameter int WORDS     = 128,
    parameter int DATA_W    = 32,
    parameter int AW        = 7,
    parameter int BW        = 5,
    parameter bit FLOP_BANK = 1'b0
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              flip_en_i,
    input  logic [AW-1:0]     flip_addr_i,
    input  logic [BW-1:0]     flip_bit_i
);

    if (FLOP_BANK) begin : g_flops
        logic [DATA_W-1:0] words [WORDS];
        for (genvar w = 0; w < WORDS; w++) begin : g_word
            logic [DATA_W-1:0] word_q;
            always_ff @(posedge clk) begin
                if (we_i && waddr_i == AW'(w)) begin
                    word_q <= wdata_i;
                end else if (flip_en_i && flip_addr_i == AW'(w)) begin
                    word_q[flip_bit_i] <= ~word_q[flip_bit_i];
                end
            end
            assign words[w] = word_q;
        end
        always_ff @(posedge clk) begin
            if (re_i) begin
                rdata_o <= words[raddr_i];
            end
        end
    end else begin : g_array
        logic [DATA_W-1:0] mem [WORDS];
        always_ff @(posedge clk) begin
            if (we_i) begin
                mem[waddr_i] <= wdata_i;
            end else if (flip_en_i) begin
                mem[flip_addr_i][flip_bit_i] <= ~mem[flip_addr_i][flip_bit_i];
            end
            if (re_i) begin
                rdata_o <= mem[raddr_i];
            end
        end
    end

endmodule

// File: rtl/scrub_dwell_timer.sv
module scrub_dwell_timer #(
    parameter int  LIMIT = 100_000_000,
    localparam int CW    = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic done_o
);

    logic [CW-1:0] cnt_q;

    assign done_o = run_i && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (done_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/scrub_err_acc.sv
module scrub_err_acc
    import scrub_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ERR_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              vld_i,
    input  logic [DATA_W-1:0] exp_i,
    input  logic [DATA_W-1:0] got_i,
    output logic [ERR_W-1:0]  err_o
);

    localparam int SUM_W = ERR_W + 8;
    localparam logic [SUM_W-1:0] SAT = SUM_W'({ERR_W{1'b1}});

    logic [7:0]       flips;
    logic [SUM_W-1:0] sum;

    always_comb begin
        flips = pop64(64'(exp_i ^ got_i));
        sum   = SUM_W'(err_o) + SUM_W'(flips);
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            err_o <= '0;
        end else if (vld_i) begin
            err_o <= (sum > SAT) ? {ERR_W{1'b1}} : sum[ERR_W-1:0];
        end
    end

    AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (vld_i && !clr_i) |=> (err_o >= $past(err_o))); // R7

endmodule

// File: rtl/scrub_tester.sv
module scrub_tester
    import scrub_pkg::*;
#(
    parameter int  DATA_W       = 32,
    parameter int  REG_WORDS    = 8,
    parameter int  DWELL_CYCLES = 100_000_000,
    parameter int  ERR_W        = 16,
    localparam int RAM_WORDS    = 16 * REG_WORDS,
    localparam int RAM_AW       = $clog2(RAM_WORDS),
    localparam int BIT_W        = $clog2(DATA_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               inj_en_i,
    input  logic               inj_ram_i,
    input  logic [RAM_AW-1:0]  inj_word_i,
    input  logic [BIT_W-1:0]   inj_bit_i,
    input  logic               rec_ready_i,
    output logic               rec_valid_o,
    output logic [CYCLE_W-1:0] rec_cycle_o,
    output logic               rec_phase_o,
    output logic [ERR_W-1:0]   rec_ram_err_o,
    output logic [ERR_W-1:0]   rec_reg_err_o,
    output logic               busy_o
);

    localparam int REG_AW = (REG_WORDS > 1) ? $clog2(REG_WORDS) : 1;

    typedef struct packed {
        logic [CYCLE_W-1:0] idx;
        logic               phase;
        logic [ERR_W-1:0]   ram_err;
        logic [ERR_W-1:0]   reg_err;
    } scrub_rec_t;

    scrub_state_e       state_q;
    logic [RAM_AW-1:0]  addr_q;
    logic               phase_q;
    logic               stop_pend_q;
    logic               rd_done_q;
    logic               rd_vld_q;
    logic               rd_last_q;
    logic               rd_reg_vld_q;
    logic [CYCLE_W-1:0] cycle_q;

    logic [DATA_W-1:0]  pat;
    logic [DATA_W-1:0]  ram_rdata;
    logic [DATA_W-1:0]  reg_rdata;
    logic               addr_last;
    logic               addr_in_reg;
    logic               wr_en;
    logic               rd_issue;
    logic               dwell_done;
    logic               accept;
    logic               acc_clr;
    logic               in_dwell;
    logic [ERR_W-1:0]   ram_err;
    logic [ERR_W-1:0]   reg_err;
    scrub_rec_t         rec;

    // Alternating pattern: phase 0 sets even bits, phase 1 sets odd bits.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            pat[i] = phase_q ^ ((i % 2) == 0);
        end
    end

    assign addr_last   = (addr_q == RAM_AW'(RAM_WORDS - 1));
    assign addr_in_reg = (addr_q < RAM_AW'(REG_WORDS));
    assign wr_en       = (state_q == ST_WRITE);
    assign in_dwell    = (state_q == ST_DWELL);
    assign rd_issue    = (state_q == ST_READ) && !rd_done_q;
    assign accept      = (state_q == ST_REPORT) && rec_ready_i;
    assign acc_clr     = in_dwell && dwell_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            addr_q       <= '0;
            phase_q      <= 1'b0;
            stop_pend_q  <= 1'b0;
            rd_done_q    <= 1'b0;
            rd_vld_q     <= 1'b0;
            rd_last_q    <= 1'b0;
            rd_reg_vld_q <= 1'b0;
            cycle_q      <= '0;
        end else begin
            rd_vld_q     <= rd_issue;
            rd_last_q    <= rd_issue && addr_last;
            rd_reg_vld_q <= rd_issue && addr_in_reg;
            if (stop_i && state_q != ST_IDLE) begin
                stop_pend_q <= 1'b1;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q     <= ST_WRITE;
                        addr_q      <= '0;
                        stop_pend_q <= 1'b0;
                    end
                end
                ST_WRITE: begin
                    if (addr_last) begin
                        state_q <= ST_DWELL;
                        addr_q  <= '0;
                    end else begin
                        addr_q <= addr_q + 1'b1;
                    end
                end
                ST_DWELL: begin
                    if (dwell_done) begin
                        state_q   <= ST_READ;
                        addr_q    <= '0;
                        rd_done_q <= 1'b0;
                    end
                end
                ST_READ: begin
                    if (rd_issue) begin
                        if (addr_last) begin
                            rd_done_q <= 1'b1;
                        end else begin
                            addr_q <= addr_q + 1'b1;
                        end
                    end
                    if (rd_vld_q && rd_last_q) begin
                        state_q <= ST_REPORT;
                    end
                end
                ST_REPORT: begin
                    if (rec_ready_i) begin
                        cycle_q <= cycle_q + 1'b1;
                        phase_q <= ~phase_q;
                        addr_q  <= '0;
                        if (stop_pend_q || stop_i) begin
                            state_q     <= ST_IDLE;
                            stop_pend_q <= 1'b0;
                        end else begin
                            state_q <= ST_WRITE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    scrub_dwell_timer #(.LIMIT(DWELL_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run_i  (in_dwell),
        .done_o (dwell_done)
    );

    scrub_store #(
        .WORDS(RAM_WORDS), .DATA_W(DATA_W), .AW(RAM_AW), .BW(BIT_W), .FLOP_BANK(1'b0)
    ) u_ram (
        .clk         (clk),
        .we_i        (wr_en),
        .waddr_i     (addr_q),
        .wdata_i     (pat),
        .re_i        (rd_issue),
        .raddr_i     (addr_q),
        .rdata_o     (ram_rdata),
        .flip_en_i   (inj_en_i && inj_ram_i && in_dwell),
        .flip_addr_i (inj_word_i),
        .flip_bit_i  (inj_bit_i)
    );

    scrub_store #(
        .WORDS(REG_WORDS), .DATA_W(DATA_W), .AW(REG_AW), .BW(BIT_W), .FLOP_BANK(1'b1)
    ) u_regs (
        .clk         (clk),
        .we_i        (wr_en && addr_in_reg),
        .waddr_i     (addr_q[REG_AW-1:0]),
        .wdata_i     (pat),
        .re_i        (rd_issue && addr_in_reg),
        .raddr_i     (addr_q[REG_AW-1:0]),
        .rdata_o     (reg_rdata),
        .flip_en_i   (inj_en_i && !inj_ram_i && in_dwell),
        .flip_addr_i (inj_word_i[REG_AW-1:0]),
        .flip_bit_i  (inj_bit_i)
    );

    scrub_err_acc #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_ram_acc (
        .clk   (clk),
        .rst   (rst),
        .clr_i (acc_clr),
        .vld_i (rd_vld_q),
        .exp_i (pat),
        .got_i (ram_rdata),
        .err_o (ram_err)
    );

    scrub_err_acc #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_reg_acc (
        .clk   (clk),
        .rst   (rst),
        .clr_i (acc_clr),
        .vld_i (rd_reg_vld_q),
        .exp_i (pat),
        .got_i (reg_rdata),
        .err_o (reg_err)
    );

    always_comb begin
        rec.idx     = cycle_q;
        rec.phase   = phase_q;
        rec.ram_err = ram_err;
        rec.reg_err = reg_err;
    end

    assign rec_valid_o   = (state_q == ST_REPORT);
    assign rec_cycle_o   = rec.idx;
    assign rec_phase_o   = rec.phase;
    assign rec_ram_err_o = rec.ram_err;
    assign rec_reg_err_o = rec.reg_err;
    assign busy_o        = (state_q != ST_IDLE);

    AST_REC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rec_valid_o && !rec_ready_i) |=> (rec_valid_o && $stable(rec_cycle_o)
            && $stable(rec_ram_err_o) && $stable(rec_reg_err_o))); // R9

    AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (rec_valid_o && rec_ready_i) |=> (cycle_q == $past(cycle_q) + 1'b1)); // R4

    AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (rst)
        (rec_valid_o && rec_ready_i) |=> (phase_q != $past(phase_q))); // R2

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        (rec_valid_o && rec_ready_i && stop_pend_q) |=> !busy_o); // R11

    AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        $rose(rec_valid_o) |-> ($past(rd_last_q) && $past(rd_vld_q))); // R3

endmodule

// File: tb/scrub_tester_tb.sv
module scrub_tester_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW   = 8;
    localparam int RW   = 2;
    localparam int N    = 16 * RW;
    localparam int D    = 20;
    localparam int EW   = 3;
    localparam int L    = 2 * N + D + 1;
    localparam int SATV = (1 << EW) - 1;
    localparam int AW   = $clog2(N);
    localparam int BW   = $clog2(DW);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          stop_i = 1'b0;
    logic          inj_en_i = 1'b0;
    logic          inj_ram_i = 1'b0;
    logic [AW-1:0] inj_word_i = '0;
    logic [BW-1:0] inj_bit_i = '0;
    logic          rec_ready_i = 1'b1;
    logic          rec_valid_o;
    logic [31:0]   rec_cycle_o;
    logic          rec_phase_o;
    logic [EW-1:0] rec_ram_err_o;
    logic [EW-1:0] rec_reg_err_o;
    logic          busy_o;

    scrub_tester #(.DATA_W(DW), .REG_WORDS(RW), .DWELL_CYCLES(D), .ERR_W(EW)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .stop_i        (stop_i),
        .inj_en_i      (inj_en_i),
        .inj_ram_i     (inj_ram_i),
        .inj_word_i    (inj_word_i),
        .inj_bit_i     (inj_bit_i),
        .rec_ready_i   (rec_ready_i),
        .rec_valid_o   (rec_valid_o),
        .rec_cycle_o   (rec_cycle_o),
        .rec_phase_o   (rec_phase_o),
        .rec_ram_err_o (rec_ram_err_o),
        .rec_reg_err_o (rec_reg_err_o),
        .busy_o        (busy_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int cnt = 0;
    always @(posedge clk) cnt <= cnt + 1;

    typedef struct {
        int idx;
        int ram;
        int regs;
        int ph;
    } exp_rec_t;

    exp_rec_t exp_q[$];
    int checks = 0;
    int errors = 0;
    int cs = 0;
    int inj_t[$];
    int inj_w[$];
    int inj_b[$];

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cnt);
        end
    endtask

    // Advance to just after the edge at which cnt becomes target.
    task automatic step_to(input int target);
        do begin
            @(posedge clk);
            #1;
        end while (cnt < target);
    endtask

    // Monitor: pops expected records at each handshake.
    always @(negedge clk) begin
        if (!rst && rec_valid_o && rec_ready_i) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected record", int'(rec_cycle_o), -1);
            end else begin
                exp_rec_t e;
                e = exp_q.pop_front();
                chk(int'(rec_cycle_o) == e.idx, "R4 cycle index", int'(rec_cycle_o), e.idx);
                chk(int'(rec_phase_o) == e.ph, "R2 phase", int'(rec_phase_o), e.ph);
                chk(int'(rec_ram_err_o) == e.ram, "R5/R7/R8 ram errors", int'(rec_ram_err_o), e.ram);
                chk(int'(rec_reg_err_o) == e.regs, "R6/R7/R8 reg errors", int'(rec_reg_err_o), e.regs);
            end
        end
    end

    task automatic add_inj(input int tgt, input int w, input int b);
        inj_t.push_back(tgt);
        inj_w.push_back(w);
        inj_b.push_back(b);
    endtask

    task automatic run_cycle(input int k, input bit stall, input bit stop);
        exp_rec_t e;
        int nr;
        int ng;
        nr = 0;
        ng = 0;
        foreach (inj_t[i]) begin
            if (inj_t[i] == 1) nr++;
            else ng++;
        end
        e.idx  = k;
        e.ram  = (nr > SATV) ? SATV : nr;
        e.regs = (ng > SATV) ? SATV : ng;
        e.ph   = k % 2;
        exp_q.push_back(e);
        if (stall) rec_ready_i = 1'b0;
        // R12: injections land on dwell edges cs+N+1 .. cs+N+D
        step_to(cs + N);
        foreach (inj_t[i]) begin
            inj_en_i   = 1'b1;
            inj_ram_i  = (inj_t[i] == 1);
            inj_word_i = AW'(inj_w[i]);
            inj_bit_i  = BW'(inj_b[i]);
            @(posedge clk);
            #1;
        end
        inj_en_i = 1'b0;
        inj_t.delete();
        inj_w.delete();
        inj_b.delete();
        if (stop) begin
            stop_i = 1'b1;
            @(posedge clk);
            #1;
            stop_i = 1'b0;
        end
        step_to(cs + L - 1);
        chk(rec_valid_o == 1'b0, "R3/R10 early valid", int'(rec_valid_o), 0);
        step_to(cs + L);
        chk(rec_valid_o == 1'b1, "R3/R10 record due", int'(rec_valid_o), 1);
        if (stall) begin
            step_to(cs + L + 4);
            chk(rec_valid_o == 1'b1, "R9 held valid", int'(rec_valid_o), 1);
            chk(int'(rec_cycle_o) == k, "R9 held index", int'(rec_cycle_o), k);
            chk(int'(rec_ram_err_o) == e.ram, "R9 held ram count", int'(rec_ram_err_o), e.ram);
            rec_ready_i = 1'b1;
            cs = cs + L + 5;
        end else begin
            cs = cs + L + 1;
        end
        step_to(cs);
        chk(rec_valid_o == 1'b0, "R10 record retired", int'(rec_valid_o), 0);
        if (stop) begin
            step_to(cs + L + 10);
            chk(busy_o == 1'b0, "R11 idle after stop", int'(busy_o), 0);
            chk(rec_valid_o == 1'b0, "R11 no further record", int'(rec_valid_o), 0);
        end
    endtask

    task automatic do_start();
        start_i = 1'b1;
        cs = cnt + 1;
        @(posedge clk);
        #1;
        start_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        chk(1'b0, "watchdog", cnt, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step_to(4);
        rst = 1'b0;
        step_to(5);
        chk(rec_valid_o == 1'b0, "R1 reset valid", int'(rec_valid_o), 0);
        chk(busy_o == 1'b0, "R1 reset busy", int'(busy_o), 0);
        step_to(200);
        chk(busy_o == 1'b0 && rec_valid_o == 1'b0, "R1 stays idle", int'(busy_o), 0);

        do_start();
        chk(busy_o == 1'b1, "R3 busy after start", int'(busy_o), 1);
        run_cycle(0, 1'b0, 1'b0);                  // R5 clean pass

        add_inj(1, 5, 3);
        add_inj(1, 31, 0);
        add_inj(1, 0, 7);
        add_inj(0, 1, 2);
        run_cycle(1, 1'b0, 1'b0);                  // R5 R6 R12

        run_cycle(2, 1'b0, 1'b0);                  // R8 no carry-over

        for (int b = 0; b < 8; b++) add_inj(1, 10, b);
        add_inj(1, 11, 0);
        add_inj(0, 0, 1);
        add_inj(0, 1, 6);
        run_cycle(3, 1'b0, 1'b0);                  // R7 saturation

        run_cycle(4, 1'b1, 1'b0);                  // R9 stall
        run_cycle(5, 1'b0, 1'b1);                  // R11 stop

        step_to(cnt + 5);
        do_start();
        add_inj(0, 0, 0);
        run_cycle(6, 1'b0, 1'b1);                  // R4 index across restart

        chk(exp_q.size() == 0, "R4 all records seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule